// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps the current date and time of day as eight packed-BCD fields: second, minute, hour, day of week, date, month, year and century. An external strobe that is high for one clock cycle each second advances the time by one second. Carries pass from seconds up to the century in the same clock edge. The hour runs on a 24-hour clock. The date wraps according to the length of the current month, and February gets its extra day in leap years.

A register interface elsewhere on the chip sets the time with a single-cycle load strobe. The strobe writes all eight fields at once and takes priority over a tick that arrives in the same cycle. All fields are always visible as parallel BCD outputs, so the register block can read them without any handshake.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After an active-low reset the fields read century 20, year 00, month 01, date 01, weekday 01, hour 00, minute 00, second 00.
- R2: On a tick the second field goes up by one. It wraps from 59 to 00 and carries into the minute field. The minute field wraps from 59 to 00 and carries into the hour field.
- R3: The hour field wraps from 23 to 00. On that wrap, the date and the day of week both advance in the same edge.
- R4: The day of week counts from 01 to 07 and then returns to 01.
- R5: In months 04, 06, 09 and 11 the date wraps from 30 to 01 and the month advances. In months 01, 03, 05, 07, 08, 10 and 12 the wrap is from 31 to 01.
- R6: February ends on date 29 in a leap year and on date 28 otherwise. For a year from 01 to 99, the year is a leap year when its value is divisible by 4. For year 00, the year is a leap year when the century value is divisible by 4.
- R7: A wrap from month 12 to 01 increments the year. A wrap of the year from 99 to 00 increments the century. The century wraps from 99 to 00.
- R8: When the load strobe is high, every field takes its load input on the next edge, whether or not a tick is present.
- R9: With neither tick nor load, every field holds its value.
- R10: Each field increments in decimal. A low digit of 9 becomes 0 and carries into the high digit, so 09 becomes 10 and 19 becomes 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe that advances the time by one second |
| load_i | input | 1 | One-cycle strobe that writes all fields from the load inputs |
| ld_century_i | input | 8 | Century value to load, BCD |
| ld_year_i | input | 8 | Year value to load, BCD |
| ld_month_i | input | 8 | Month value to load, BCD 01..12 |
| ld_date_i | input | 8 | Date value to load, BCD 01..31 |
| ld_wday_i | input | 8 | Day-of-week value to load, BCD 01..07 |
| ld_hour_i | input | 8 | Hour value to load, BCD 00..23 |
| ld_minute_i | input | 8 | Minute value to load, BCD 00..59 |
| ld_second_i | input | 8 | Second value to load, BCD 00..59 |
| century_o | output | 8 | Current century, BCD |
| year_o | output | 8 | Current year, BCD |
| month_o | output | 8 | Current month, BCD |
| date_o | output | 8 | Current date, BCD |
| wday_o | output | 8 | Current day of week, BCD |
| hour_o | output | 8 | Current hour, BCD |
| minute_o | output | 8 | Current minute, BCD |
| second_o | output | 8 | Current second, BCD |

## Verification
The bench loads the last second of chosen days and then ticks once. It covers Feb 28 in a common year, in a leap year, in century year 2000 and in century year 1900, as well as Feb 29, Apr 30, Dec 31 and year 99 with century 99. A design that applied the divisible-by-4 rule alone would give 1900 a Feb 29. A design that ignored month length would show Apr 31 or Feb 30. A binary-style increment would produce 0A where 10 is expected. A load that lost to a same-cycle tick would come out one second late. An hour wrap that skipped the weekday, or a weekday that wrapped to 00 instead of 01, shows up in the day-of-week field.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

    localparam int DIGITS  = 2;
    localparam int FIELD_W = 4 * DIGITS;

    typedef logic [FIELD_W-1:0] bcd_t;

    typedef struct packed {
        bcd_t century;
        bcd_t year;
        bcd_t month;
        bcd_t date;
        bcd_t wday;
        bcd_t hour;
        bcd_t minute;
        bcd_t second;
    } cal_time_t;

    // True when a two-digit BCD value is a multiple of four:
    // even tens need ones of 0/4/8, odd tens need ones of 2/6.
    function automatic logic bcd_div4(input bcd_t v);
        logic [3:0] tens;
        logic [3:0] ones;
        tens = v[7:4];
        ones = v[3:0];
        if (tens[0]) return (ones == 4'd2) || (ones == 4'd6);
        else         return (ones == 4'd0) || (ones == 4'd4) || (ones == 4'd8);
    endfunction

endpackage

// File: rtl/bcd_field_inc.sv
module bcd_field_inc
    import bcd_cal_pkg::*;
(
    input  bcd_t val_i,
    input  logic en_i,
    input  bcd_t lo_i,
    input  bcd_t hi_i,
    output bcd_t nxt_o,
    output logic wrap_o
);
    logic carry;

    always_comb begin
        wrap_o = en_i && (val_i == hi_i);
        nxt_o  = val_i;
        carry  = 1'b1;
        if (wrap_o) begin
            nxt_o = lo_i;
        end else if (en_i) begin
            for (int i = 0; i < DIGITS; i++) begin
                if (carry) begin
                    if (val_i[4*i +: 4] >= 4'd9) begin
                        nxt_o[4*i +: 4] = 4'd0;
                    end else begin
                        nxt_o[4*i +: 4] = val_i[4*i +: 4] + 4'd1;
                        carry           = 1'b0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/bcd_month_len.sv
module bcd_month_len
    import bcd_cal_pkg::*;
(
    input  bcd_t month_i,
    input  bcd_t year_i,
    input  bcd_t century_i,
    output logic leap_o,
    output bcd_t last_date_o
);
    always_comb begin
        if (year_i == '0) leap_o = bcd_div4(century_i);
        else              leap_o = bcd_div4(year_i);

        unique case (month_i)
            8'h02:                      last_date_o = leap_o ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_date_o = 8'h30;
            default:                    last_date_o = 8'h31;
        endcase
    end
endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
    import bcd_cal_pkg::*;
#(
    parameter bcd_t RST_CENTURY = 8'h20,
    parameter bcd_t WDAY_FIRST  = 8'h01,
    parameter bcd_t WDAY_LAST   = 8'h07
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_i,
    input  logic       load_i,
    input  logic [7:0] ld_century_i,
    input  logic [7:0] ld_year_i,
    input  logic [7:0] ld_month_i,
    input  logic [7:0] ld_date_i,
    input  logic [7:0] ld_wday_i,
    input  logic [7:0] ld_hour_i,
    input  logic [7:0] ld_minute_i,
    input  logic [7:0] ld_second_i,
    output logic [7:0] century_o,
    output logic [7:0] year_o,
    output logic [7:0] month_o,
    output logic [7:0] date_o,
    output logic [7:0] wday_o,
    output logic [7:0] hour_o,
    output logic [7:0] minute_o,
    output logic [7:0] second_o
);
    localparam int NF = 8;   // fields, index 0 = second .. 7 = century

    cal_time_t t_d, t_q;
    cal_time_t inc_time;
    logic      leap;
    bcd_t      last_date;

    bcd_t cur  [NF];
    bcd_t lo   [NF];
    bcd_t hi   [NF];
    logic en   [NF];
    bcd_t nxt  [NF];
    logic wrap [NF];
    logic day_roll;

    bcd_month_len u_mlen (
        .month_i    (t_q.month),
        .year_i     (t_q.year),
        .century_i  (t_q.century),
        .leap_o     (leap),
        .last_date_o(last_date)
    );

    // Field map and ripple enables. Weekday (4) and date (3) both
    // take the hour wrap; month takes the date wrap.
    always_comb begin
        cur[0] = t_q.second;  lo[0] = 8'h00;      hi[0] = 8'h59;
        cur[1] = t_q.minute;  lo[1] = 8'h00;      hi[1] = 8'h59;
        cur[2] = t_q.hour;    lo[2] = 8'h00;      hi[2] = 8'h23;
        cur[3] = t_q.date;    lo[3] = 8'h01;      hi[3] = last_date;
        cur[4] = t_q.wday;    lo[4] = WDAY_FIRST; hi[4] = WDAY_LAST;
        cur[5] = t_q.month;   lo[5] = 8'h01;      hi[5] = 8'h12;
        cur[6] = t_q.year;    lo[6] = 8'h00;      hi[6] = 8'h99;
        cur[7] = t_q.century; lo[7] = 8'h00;      hi[7] = 8'h99;

        day_roll = wrap[2];
        en[0] = tick_i;
        en[1] = wrap[0];
        en[2] = wrap[1];
        en[3] = day_roll;
        en[4] = day_roll;
        en[5] = wrap[3];
        en[6] = wrap[5];
        en[7] = wrap[6];
    end

    for (genvar g = 0; g < NF; g++) begin : g_field
        bcd_field_inc u_inc (
            .val_i (cur[g]),
            .en_i  (en[g]),
            .lo_i  (lo[g]),
            .hi_i  (hi[g]),
            .nxt_o (nxt[g]),
            .wrap_o(wrap[g])
        );
    end

    always_comb begin
        inc_time = '{century: nxt[7], year: nxt[6], month: nxt[5], date: nxt[3],
                     wday: nxt[4], hour: nxt[2], minute: nxt[1], second: nxt[0]};
        if (load_i) begin
            t_d = '{century: ld_century_i, year: ld_year_i, month: ld_month_i,
                    date: ld_date_i, wday: ld_wday_i, hour: ld_hour_i,
                    minute: ld_minute_i, second: ld_second_i};
        end else if (tick_i) begin
            t_d = inc_time;
        end else begin
            t_d = t_q;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            t_q <= '{century: RST_CENTURY, year: 8'h00, month: 8'h01, date: 8'h01,
                     wday: WDAY_FIRST, hour: 8'h00, minute: 8'h00, second: 8'h00};
        end else begin
            t_q <= t_d;
        end
    end

    assign century_o = t_q.century;
    assign year_o    = t_q.year;
    assign month_o   = t_q.month;
    assign date_o    = t_q.date;
    assign wday_o    = t_q.wday;
    assign hour_o    = t_q.hour;
    assign minute_o  = t_q.minute;
    assign second_o  = t_q.second;

    a_r2_sec_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !load_i && t_q.second == 8'h59) |=> (second_o == 8'h00))
        else $error("R2 second wrap");

    a_r3_hour_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && day_roll) |=> (hour_o == 8'h00 && date_o != $past(date_o)))
        else $error("R3 hour wrap");

    a_r4_wday_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && day_roll && t_q.wday == WDAY_LAST) |=> (wday_o == WDAY_FIRST))
        else $error("R4 weekday wrap");

    a_r6_feb_common: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && day_roll && !leap && t_q.month == 8'h02 && t_q.date == 8'h28)
        |=> (month_o == 8'h03 && date_o == 8'h01))
        else $error("R6 february end");

    a_r8_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (second_o == $past(ld_second_i) && year_o == $past(ld_year_i)))
        else $error("R8 load priority");

    a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && !tick_i) |=> $stable(t_q))
        else $error("R9 hold");

endmodule

// File: tb/bcd_calendar_clock_bench.sv
module bcd_calendar_clock_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       load = 1'b0;
    logic [63:0] ld = '0;
    logic [7:0] c_o, y_o, mo_o, d_o, w_o, h_o, mi_o, s_o;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bcd_calendar_clock u_bcd_calendar_clock (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .load_i(load),
        .ld_century_i(ld[63:56]), .ld_year_i(ld[55:48]), .ld_month_i(ld[47:40]),
        .ld_date_i(ld[39:32]), .ld_wday_i(ld[31:24]), .ld_hour_i(ld[23:16]),
        .ld_minute_i(ld[15:8]), .ld_second_i(ld[7:0]),
        .century_o(c_o), .year_o(y_o), .month_o(mo_o), .date_o(d_o),
        .wday_o(w_o), .hour_o(h_o), .minute_o(mi_o), .second_o(s_o)
    );

    // packed view: century year month date wday hour minute second
    function automatic logic [63:0] now();
        return {c_o, y_o, mo_o, d_o, w_o, h_o, mi_o, s_o};
    endfunction

    task automatic check(input string req, input logic [63:0] exp);
        n_chk++;
        if (now() !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, now(), exp);
        end
    endtask

    // load at one edge; optionally tick alongside
    task automatic do_load(input logic [63:0] v, input bit with_tick);
        @(negedge clk);
        ld = v; load = 1'b1; tick = with_tick;
        @(negedge clk);
        load = 1'b0; tick = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic roll_case(input string req, input logic [63:0] start, input logic [63:0] exp);
        do_load(start, 1'b0);
        do_tick();
        check(req, exp);
    endtask

    task automatic t_reset();
        check("R1 reset", 64'h20_00_01_01_01_00_00_00);
    endtask

    task automatic t_hold();
        do_load(64'h20_24_03_15_03_10_20_30, 1'b0);
        repeat (5) @(negedge clk);
        check("R9 hold", 64'h20_24_03_15_03_10_20_30);
    endtask

    task automatic t_digits();
        roll_case("R10 09->10", 64'h20_24_03_15_03_10_09_09, 64'h20_24_03_15_03_10_09_10);
        roll_case("R10 19->20", 64'h20_24_03_15_03_10_09_19, 64'h20_24_03_15_03_10_09_20);
        roll_case("R2 min carry", 64'h20_24_03_15_03_10_59_59, 64'h20_24_03_15_03_11_00_00);
        roll_case("R2 sec carry", 64'h20_24_03_15_03_10_09_59, 64'h20_24_03_15_03_10_10_00);
    endtask

    task automatic t_day();
        roll_case("R3 midnight", 64'h20_24_03_15_03_23_59_59, 64'h20_24_03_16_04_00_00_00);
        roll_case("R4 wday wrap", 64'h20_24_03_15_07_23_59_59, 64'h20_24_03_16_01_00_00_00);
    endtask

    task automatic t_months();
        roll_case("R5 apr30", 64'h20_24_04_30_02_23_59_59, 64'h20_24_05_01_03_00_00_00);
        roll_case("R5 jan30", 64'h20_24_01_30_02_23_59_59, 64'h20_24_01_31_03_00_00_00);
        roll_case("R5 jan31", 64'h20_24_01_31_02_23_59_59, 64'h20_24_02_01_03_00_00_00);
        roll_case("R5 nov30", 64'h20_24_11_30_02_23_59_59, 64'h20_24_12_01_03_00_00_00);
    endtask

    task automatic t_feb();
        roll_case("R6 feb28 2023", 64'h20_23_02_28_02_23_59_59, 64'h20_23_03_01_03_00_00_00);
        roll_case("R6 feb28 2024", 64'h20_24_02_28_02_23_59_59, 64'h20_24_02_29_03_00_00_00);
        roll_case("R6 feb29 2024", 64'h20_24_02_29_02_23_59_59, 64'h20_24_03_01_03_00_00_00);
        roll_case("R6 feb28 2000", 64'h20_00_02_28_02_23_59_59, 64'h20_00_02_29_03_00_00_00);
        roll_case("R6 feb28 1900", 64'h19_00_02_28_02_23_59_59, 64'h19_00_03_01_03_00_00_00);
        roll_case("R6 feb28 2010", 64'h20_10_02_28_02_23_59_59, 64'h20_10_03_01_03_00_00_00);
    endtask

    task automatic t_year();
        roll_case("R7 dec31", 64'h20_24_12_31_02_23_59_59, 64'h20_25_01_01_03_00_00_00);
        roll_case("R7 year99", 64'h20_99_12_31_02_23_59_59, 64'h21_00_01_01_03_00_00_00);
        roll_case("R7 century99", 64'h99_99_12_31_02_23_59_59, 64'h00_00_01_01_03_00_00_00);
    endtask

    task automatic t_load_prio();
        do_load(64'h20_24_06_10_05_12_34_56, 1'b1);
        check("R8 load beats tick", 64'h20_24_06_10_05_12_34_56);
        do_load(64'h19_87_07_04_06_23_59_59, 1'b1);
        check("R8 load at rollover", 64'h19_87_07_04_06_23_59_59);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hold();
        t_digits();
        t_day();
        t_months();
        t_feb();
        t_year();
        t_load_prio();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule